// File: doc/BRIEF.md
# Serial Command and Register Port

This block is the serial slave of a multichannel data-converter core. A bus master talks to it over four wires: an active-low select, a serial clock that idles low, a data line into the block and a data line out of it. Bytes arriving on the input are decoded as command opcodes. A one-byte opcode becomes a one-cycle strobe to the conversion controller. Two-byte headers open a burst read or a burst write of a small 8-bit register file.

The output line carries one of two things. It shifts out the current conversion frame, which the controller presents in parallel, or it shifts out the register bytes that a read asked for. A continuous-read mode reloads each new frame automatically. In that mode the decoder listens only for the opcode that ends it.

When the chain mode bit is set, bits arriving on a second serial input follow the local frame out. This lets several converters share one output line in series. The serial pins are brought into the system clock domain through synchronizers. All decoding runs on the system clock.

Top module: `spi_cmd_slave`

## Requirements
- R1: `sdo` is high-impedance whenever `cs_n` is high, including directly after reset.
- R2: Input bits are taken MSB first on falling `sclk` edges. Output bits change on rising `sclk` edges, MSB first, so the first output bit of a byte appears on its first rising edge.
- R3: The opcodes 08h, 0Ah and 12h each give exactly one pulse, on `conv_start`, `conv_stop` and `read_once` respectively, once the eighth falling edge of the byte has been taken. An undefined opcode such as FFh gives no pulse.
- R4: The opcode 06h pulses `soft_reset` on its eighth falling edge and returns every register to its reset value (zero, except for the fixed bits of R8).
- R5: A write header 010a_aaaa (5-bit start address) is followed by a byte N. The next N+1 bytes are then written to consecutive addresses.
- R6: A read header 001a_aaaa is followed by a byte N. During the next N+1 bytes, `sdo` carries the registers from consecutive addresses, MSB first.
- R7: Address 00h always reads the parameter `ID_VALUE`, and writes to it are ignored. Addresses at or above `NREG` read zero and ignore writes.
- R8: Fixed bits always hold their required values, whatever is written:
  - 01h: bits 7, 4 and 3 are 0.
  - 02h: bits 7, 6 and 3 are 0, and bit 5 is 1.
  - 05h to 0Ch: bit 3 is 0.
  - 17h: bits 7 to 4 and bit 0 are 0.
- R9: Raising `cs_n` discards a partly received byte. The next byte after `cs_n` falls is then decoded as a fresh opcode.
- R10: Opcode 10h enters continuous-read mode and pulses `cont_enter`. Opcode 11h leaves it and pulses `cont_exit`. While the mode is on, every other opcode, including register reads and writes, is ignored. Each `frame_valid` loads the new frame for shifting.
- R11: After opcode 12h, `sdo` carries the frame most recently captured on `frame_valid`. The frame is the 24-bit status followed by the channel samples, channel 0 first (`frame_samples[15:0]`), each sent MSB first.
- R12: When register 01h bit 6 is 1, bits on `daisy_in` taken on rising `sclk` edges appear on `sdo` after the local frame, delayed by exactly the frame length. When that bit is 0, zeros follow the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master, high-Z when deselected |
| daisy_in | input | 1 | Serial data from the next device in a chain |
| frame_valid | input | 1 | Pulse: new conversion frame on the frame inputs |
| frame_status | input | 24 | Status word of the frame |
| frame_samples | input | NCH*16 | Samples, channel k at bits [16k+15:16k] |
| conv_start | output | 1 | Start-conversion strobe |
| conv_stop | output | 1 | Stop-conversion strobe |
| soft_reset | output | 1 | Command reset strobe |
| read_once | output | 1 | One-shot frame read strobe |
| cont_enter | output | 1 | Continuous-read entered strobe |
| cont_exit | output | 1 | Continuous-read left strobe |
| reg_image | output | NREG*8 | Register file, address a at bits [8a+7:8a] |

## Verification
The assertions assume that each `sclk` phase lasts several system clocks, longer than the two synchronizer stages plus edge detection. They also assume that `cs_n` moves only while `sclk` is low, and that `frame_valid` never coincides with the completion of a byte that itself loads the shifter. The stimulus keeps to these rules: every phase lasts eight clocks, all pins are driven on the falling system clock, and four to six idle clocks surround each edge of `cs_n`. Frames are presented only while the bus is idle.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int STATUS_W = 24;
    localparam int SAMPLE_W = 16;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 5;

    typedef enum logic [1:0] {
        DEC_OPCODE,
        DEC_COUNT,
        DEC_WRITE,
        DEC_READ
    } dec_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic reset;
        logic read_once;
        logic cont_on;
        logic cont_off;
    } cmd_strobe_t;

    localparam logic [7:0] OP_RESET     = 8'h06;
    localparam logic [7:0] OP_START     = 8'h08;
    localparam logic [7:0] OP_STOP      = 8'h0A;
    localparam logic [7:0] OP_CONT_ON   = 8'h10;
    localparam logic [7:0] OP_CONT_OFF  = 8'h11;
    localparam logic [7:0] OP_READ_ONCE = 8'h12;
    localparam logic [2:0] PFX_READ     = 3'b001;
    localparam logic [2:0] PFX_WRITE    = 3'b010;

    // Bits that are held at a required value regardless of writes.
    function automatic logic [7:0] fixed_mask(input logic [ADDR_W-1:0] a);
        if (a == 5'h01)                      return 8'h98;
        else if (a == 5'h02)                 return 8'hE8;
        else if (a >= 5'h05 && a <= 5'h0C)   return 8'h08;
        else if (a == 5'h17)                 return 8'hF1;
        else                                 return 8'h00;
    endfunction

    function automatic logic [7:0] fixed_value(input logic [ADDR_W-1:0] a);
        if (a == 5'h02) return 8'h20;
        else            return 8'h00;
    endfunction

    function automatic logic [7:0] apply_fixed(input logic [ADDR_W-1:0] a,
                                               input logic [7:0] d);
        return (d & ~fixed_mask(a)) | (fixed_value(a) & fixed_mask(a));
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    output logic [W-1:0] pins_s
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= pins;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= chain[s-1];
        end
    end

    assign pins_s = chain[STAGES-1];
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              fall,
    input  logic              sdi,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else if (!cs_active) begin
            bit_cnt   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (fall) begin
                shreg   <= {shreg[BYTE_W-3:0], sdi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {shreg, sdi};
                end
            end
        end
    end

    // R9: a deselect leaves no partial bit count behind
    assert_abort_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> (bit_cnt == '0) && !byte_done);

    // R2: a completed byte is always the product of a falling edge
    assert_byte_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> $past(fall));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int FRAME_W = 152
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_data,
    input  logic               shift,
    input  logic               fill_bit,
    output logic               out_bit
);
    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            out_bit <= 1'b0;
        end else if (load) begin
            sr <= load_data;
        end else if (shift) begin
            out_bit <= sr[FRAME_W-1];
            sr      <= {sr[FRAME_W-2:0], fill_bit};
        end
    end

    // R11: a loaded word starts from its own MSB
    assert_load_msb_R11: assert property (@(posedge clk) disable iff (rst)
        load |=> sr[FRAME_W-1] == $past(load_data[FRAME_W-1]));

    // R2: every rising edge presents the bit that was at the head
    assert_shift_out_R2: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> out_bit == $past(sr[FRAME_W-1]));
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
    import spi_cmd_pkg::*;
#(
    parameter int         NREG     = 26,
    parameter logic [7:0] ID_VALUE = 8'h92
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] image
);
    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_id
            assign regs[g] = ID_VALUE;
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst || soft_clr)
                    q <= fixed_value(ADDR_W'(g));
                else if (wr_en && wr_addr == ADDR_W'(g))
                    q <= apply_fixed(ADDR_W'(g), wr_data);
            end
            assign regs[g] = q;
        end
        assign image[g*8 +: 8] = regs[g];
    end

    always_comb begin
        if (int'(rd_addr) < NREG) rd_data = regs[rd_addr];
        else                      rd_data = 8'h00;
    end

    // R4: a command reset puts the chain-mode register back to zero
    assert_soft_clear_R4: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> image[15:8] == 8'h00);

    // R8: the always-one bit of register 02h survives any write
    assert_fixed_one_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 5'h02) |=> image[21]);
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int         NCH      = 8,
    parameter int         NREG     = 26,
    parameter logic [7:0] ID_VALUE = 8'h92
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  sdi,
    output logic                  sdo,
    input  logic                  daisy_in,
    input  logic                  frame_valid,
    input  logic [STATUS_W-1:0]   frame_status,
    input  logic [NCH*SAMPLE_W-1:0] frame_samples,
    output logic                  conv_start,
    output logic                  conv_stop,
    output logic                  soft_reset,
    output logic                  read_once,
    output logic                  cont_enter,
    output logic                  cont_exit,
    output logic [NREG*8-1:0]     reg_image
);
    localparam int FRAME_W   = STATUS_W + NCH * SAMPLE_W;
    localparam int DAISY_BIT = 6;

    // Pin synchronization and edge detection
    logic [3:0] pins_s;
    logic       cs_n_s, sclk_s, sdi_s, daisy_s, sclk_d;
    logic       cs_active, sclk_rise, sclk_fall;

    spi_pin_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1000)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pins  ({cs_n, sclk, sdi, daisy_in}),
        .pins_s(pins_s)
    );
    assign {cs_n_s, sclk_s, sdi_s, daisy_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    assign cs_active = !cs_n_s;
    assign sclk_rise = cs_active && sclk_s && !sclk_d;
    assign sclk_fall = cs_active && !sclk_s && sclk_d;

    // Byte assembly
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;

    spi_byte_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .cs_active(cs_active),
        .fall     (sclk_fall),
        .sdi      (sdi_s),
        .byte_done(byte_done),
        .rx_byte  (rx_byte)
    );

    // Frame packing and capture
    logic [FRAME_W-1:0] frame_packed, frame_hold;

    assign frame_packed[FRAME_W-1 -: STATUS_W] = frame_status;
    for (genvar k = 0; k < NCH; k++) begin : g_pack
        assign frame_packed[FRAME_W-STATUS_W-1-k*SAMPLE_W -: SAMPLE_W] =
            frame_samples[k*SAMPLE_W +: SAMPLE_W];
    end

    always_ff @(posedge clk) begin
        if (rst)              frame_hold <= '0;
        else if (frame_valid) frame_hold <= frame_packed;
    end

    // Command decoder
    dec_state_e        state_q;
    logic              cont_q, is_read_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        remain_q;
    cmd_strobe_t       strb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= DEC_OPCODE;
            cont_q    <= 1'b0;
            is_read_q <= 1'b0;
            addr_q    <= '0;
            remain_q  <= '0;
            strb_q    <= '0;
        end else begin
            strb_q <= '0;
            if (!cs_active) begin
                state_q <= DEC_OPCODE;
            end else if (byte_done) begin
                unique case (state_q)
                    DEC_OPCODE: begin
                        if (cont_q) begin
                            if (rx_byte == OP_CONT_OFF) begin
                                cont_q          <= 1'b0;
                                strb_q.cont_off <= 1'b1;
                            end
                        end else if (rx_byte[7:5] == PFX_READ) begin
                            is_read_q <= 1'b1;
                            addr_q    <= rx_byte[ADDR_W-1:0];
                            state_q   <= DEC_COUNT;
                        end else if (rx_byte[7:5] == PFX_WRITE) begin
                            is_read_q <= 1'b0;
                            addr_q    <= rx_byte[ADDR_W-1:0];
                            state_q   <= DEC_COUNT;
                        end else begin
                            case (rx_byte)
                                OP_RESET:     strb_q.reset     <= 1'b1;
                                OP_START:     strb_q.start     <= 1'b1;
                                OP_STOP:      strb_q.stop      <= 1'b1;
                                OP_READ_ONCE: strb_q.read_once <= 1'b1;
                                OP_CONT_ON: begin
                                    cont_q         <= 1'b1;
                                    strb_q.cont_on <= 1'b1;
                                end
                                OP_CONT_OFF:  strb_q.cont_off  <= 1'b1;
                                default: ;
                            endcase
                        end
                    end
                    DEC_COUNT: begin
                        remain_q <= rx_byte;
                        state_q  <= is_read_q ? DEC_READ : DEC_WRITE;
                    end
                    DEC_WRITE, DEC_READ: begin
                        addr_q <= addr_q + 1'b1;
                        if (remain_q == 8'd0) state_q  <= DEC_OPCODE;
                        else                  remain_q <= remain_q - 1'b1;
                    end
                    default: state_q <= DEC_OPCODE;
                endcase
            end
        end
    end

    assign conv_start = strb_q.start;
    assign conv_stop  = strb_q.stop;
    assign soft_reset = strb_q.reset;
    assign read_once  = strb_q.read_once;
    assign cont_enter = strb_q.cont_on;
    assign cont_exit  = strb_q.cont_off;

    // Register file
    logic              wr_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;

    assign wr_en   = byte_done && cs_active && (state_q == DEC_WRITE);
    assign rd_addr = (state_q == DEC_READ) ? addr_q + 1'b1 : addr_q;

    spi_regfile #(.NREG(NREG), .ID_VALUE(ID_VALUE)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .soft_clr(strb_q.reset),
        .wr_en   (wr_en),
        .wr_addr (addr_q),
        .wr_data (rx_byte),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .image   (reg_image)
    );

    // Output shifter load selection
    logic               load_en;
    logic [FRAME_W-1:0] load_data;

    always_comb begin
        load_en   = 1'b0;
        load_data = frame_packed;
        if (byte_done && cs_active) begin
            if (state_q == DEC_COUNT && is_read_q) begin
                load_en   = 1'b1;
                load_data = {rd_data, {(FRAME_W-8){1'b0}}};
            end else if (state_q == DEC_READ && remain_q != 8'd0) begin
                load_en   = 1'b1;
                load_data = {rd_data, {(FRAME_W-8){1'b0}}};
            end else if (state_q == DEC_OPCODE && !cont_q &&
                         rx_byte == OP_READ_ONCE) begin
                load_en   = 1'b1;
                load_data = frame_hold;
            end
        end
        if (!load_en && cont_q && frame_valid) begin
            load_en   = 1'b1;
            load_data = frame_packed;
        end
    end

    logic sdo_bit;

    spi_tx_shift #(.FRAME_W(FRAME_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (load_en),
        .load_data(load_data),
        .shift    (sclk_rise),
        .fill_bit (reg_image[8 + DAISY_BIT] & daisy_s),
        .out_bit  (sdo_bit)
    );

    assign sdo = cs_n ? 1'bz : sdo_bit;

    // R3: command strobes never overlap
    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({conv_start, conv_stop, soft_reset, read_once, cont_enter, cont_exit}));

    // R10: no register write can happen while continuous mode is on
    assert_cont_blocks_write_R10: assert property (@(posedge clk) disable iff (rst)
        (cont_q && byte_done) |-> !wr_en);

    // R10: strobes other than the exit never fire in continuous mode
    assert_cont_silences_R10: assert property (@(posedge clk) disable iff (rst)
        $past(cont_q) && cont_q |-> !(conv_start || conv_stop || soft_reset || read_once));
endmodule

// File: tb/sim_spi_cmd_slave.sv
`timescale 1ns/1ps
module sim_spi_cmd_slave;
    localparam int         NCH  = 8;
    localparam int         NREG = 26;
    localparam logic [7:0] ID   = 8'h92;
    localparam int         FW   = 24 + NCH * 16;
    localparam int         FB   = FW / 8;
    localparam int         HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, daisy_in = 1'b0;
    logic frame_valid = 1'b0;
    logic [23:0]       frame_status = '0;
    logic [NCH*16-1:0] frame_samples = '0;
    logic sdo, conv_start, conv_stop, soft_reset, read_once, cont_enter, cont_exit;
    logic [NREG*8-1:0] reg_image;

    always #2.5 clk = ~clk;

    spi_cmd_slave #(.NCH(NCH), .NREG(NREG), .ID_VALUE(ID)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .daisy_in(daisy_in), .frame_valid(frame_valid), .frame_status(frame_status),
        .frame_samples(frame_samples), .conv_start(conv_start), .conv_stop(conv_stop),
        .soft_reset(soft_reset), .read_once(read_once), .cont_enter(cont_enter),
        .cont_exit(cont_exit), .reg_image(reg_image)
    );

    int n_start = 0, n_stop = 0, n_reset = 0, n_once = 0, n_enter = 0, n_exit = 0;
    always @(posedge clk) begin
        if (conv_start) n_start++;
        if (conv_stop)  n_stop++;
        if (soft_reset) n_reset++;
        if (read_once)  n_once++;
        if (cont_enter) n_enter++;
        if (cont_exit)  n_exit++;
    end

    int checks = 0, errors = 0;
    logic [7:0]    rbuf [0:31];
    logic [FW-1:0] exp_frame;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] dz, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            sdi = tx[i]; daisy_in = dz[i]; sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            rx[i] = sdo;
            sclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (6) @(negedge clk); cs_n = 1'b1; daisy_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] op);
        logic [7:0] rx;
        cs_low(); xfer(op, 8'h00, rx); cs_high();
    endtask

    task automatic write_regs(input logic [4:0] a, input int n,
                              input logic [7:0] v0, input logic [7:0] v1, input logic [7:0] v2);
        logic [7:0] rx;
        logic [7:0] v [3];
        v[0] = v0; v[1] = v1; v[2] = v2;
        cs_low();
        xfer({3'b010, a}, 8'h00, rx);
        xfer(8'(n - 1), 8'h00, rx);
        for (int i = 0; i < n; i++) xfer(v[i], 8'h00, rx);
        cs_high();
    endtask

    task automatic read_regs(input logic [4:0] a, input int n);
        logic [7:0] rx;
        cs_low();
        xfer({3'b001, a}, 8'h00, rx);
        xfer(8'(n - 1), 8'h00, rx);
        for (int i = 0; i < n; i++) begin xfer(8'h00, 8'h00, rx); rbuf[i] = rx; end
        cs_high();
    endtask

    task automatic present_frame(input logic [23:0] st, input logic [15:0] seed);
        @(negedge clk);
        frame_status = st;
        for (int k = 0; k < NCH; k++) frame_samples[k*16 +: 16] = seed ^ 16'(k * 16'h1357);
        exp_frame[FW-1 -: 24] = st;
        for (int k = 0; k < NCH; k++) exp_frame[FW-25-k*16 -: 16] = seed ^ 16'(k * 16'h1357);
        frame_valid = 1'b1;
        @(negedge clk); frame_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] rg(input int a);
        return reg_image[a*8 +: 8];
    endfunction

    task automatic t_reset_state();
        chk("R1 sdo high-Z after reset", {63'b0, sdo}, {63'b0, 1'bz});
        chk("R4 reg 01h reset value", rg(1), 8'h00);
        chk("R8 reg 02h reset value", rg(2), 8'h20);
        chk("R3 no strobes in reset", n_start + n_stop + n_reset + n_once, 0);
    endtask

    task automatic t_strobes();
        send_cmd(8'h08); chk("R3 start pulse", n_start, 1);
        send_cmd(8'h0A); chk("R3 stop pulse", n_stop, 1);
        send_cmd(8'hFF);
        chk("R3 undefined opcode silent", n_start + n_stop + n_reset + n_once, 2);
    endtask

    task automatic t_write_read();
        write_regs(5'h05, 3, 8'hFF, 8'h12, 8'hA5);
        chk("R5 R8 write 05h bit3 forced", rg(5), 8'hF7);
        chk("R5 write autoinc 06h", rg(6), 8'h12);
        chk("R5 write autoinc 07h", rg(7), 8'hA5);
        read_regs(5'h05, 3);
        chk("R6 read 05h", rbuf[0], 8'hF7);
        chk("R6 read autoinc 06h", rbuf[1], 8'h12);
        chk("R6 read autoinc 07h", rbuf[2], 8'hA5);
    endtask

    task automatic t_fixed_and_id();
        write_regs(5'h00, 1, 8'h00, 8'h00, 8'h00);
        read_regs(5'h00, 1);
        chk("R7 ID register read-only", rbuf[0], {56'b0, ID});
        write_regs(5'h17, 1, 8'hFF, 8'h00, 8'h00);
        chk("R8 reg 17h fixed bits", rg(23), 8'h0E);
        write_regs(5'h02, 1, 8'h00, 8'h00, 8'h00);
        chk("R8 reg 02h bit5 held", rg(2), 8'h20);
        write_regs(5'h01, 1, 8'hFF, 8'h00, 8'h00);
        chk("R8 reg 01h fixed bits", rg(1), 8'h67);
        write_regs(5'h1E, 1, 8'hAB, 8'h00, 8'h00);
        read_regs(5'h1E, 1);
        chk("R7 out-of-range reads zero", rbuf[0], 8'h00);
        write_regs(5'h01, 1, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        int s0 = n_start, r0 = n_reset;
        cs_low();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); sdi = 1'b1; sclk = 1'b1;
            repeat (HALF) @(negedge clk); sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_high();
        cs_low(); xfer(8'h08, 8'h00, rx); cs_high();
        chk("R9 fresh opcode after abort", n_start - s0, 1);
        chk("R9 no stray reset", n_reset - r0, 0);
    endtask

    task automatic t_read_once();
        logic [7:0] rx;
        logic [FW-1:0] got;
        present_frame(24'hA50F3C, 16'h8001);
        cs_low();
        xfer(8'h12, 8'h00, rx);
        for (int b = 0; b < FB; b++) begin xfer(8'h00, 8'h00, rx); got[FW-1-b*8 -: 8] = rx; end
        cs_high();
        chk("R3 read_once pulse", n_once, 1);
        chk("R11 R2 status word", got[FW-1 -: 24], exp_frame[FW-1 -: 24]);
        chk("R11 channel 0 sample", got[FW-25 -: 16], exp_frame[FW-25 -: 16]);
        chk("R11 last channel sample", got[15:0], exp_frame[15:0]);
    endtask

    task automatic t_continuous();
        logic [7:0] rx;
        logic [FW-1:0] got;
        int s0;
        send_cmd(8'h10);
        chk("R10 enter pulse", n_enter, 1);
        write_regs(5'h05, 1, 8'h33, 8'h00, 8'h00);
        chk("R10 write ignored in continuous mode", rg(5), 8'hF7);
        s0 = n_start;
        send_cmd(8'h08);
        chk("R10 start ignored in continuous mode", n_start - s0, 0);
        present_frame(24'h5AF0C3, 16'h4C21);
        cs_low();
        for (int b = 0; b < FB; b++) begin xfer(8'h00, 8'h00, rx); got[FW-1-b*8 -: 8] = rx; end
        cs_high();
        chk("R10 frame reloaded on valid", got, exp_frame);
        send_cmd(8'h11);
        chk("R10 exit pulse", n_exit, 1);
        send_cmd(8'h08);
        chk("R10 start honoured after exit", n_start - s0, 1);
    endtask

    task automatic t_daisy();
        logic [7:0] rx;
        write_regs(5'h01, 1, 8'h40, 8'h00, 8'h00);
        present_frame(24'h123456, 16'h0F0F);
        cs_low();
        xfer(8'h12, 8'h00, rx);
        for (int b = 0; b <= FB; b++) begin
            xfer(8'h00, (b == 0) ? 8'h3C : 8'h00, rx);
            if (b == FB) chk("R12 chained bits follow frame", rx, 8'h3C);
        end
        cs_high();
        write_regs(5'h01, 1, 8'h00, 8'h00, 8'h00);
        cs_low();
        xfer(8'h12, 8'h00, rx);
        for (int b = 0; b <= FB; b++) begin
            xfer(8'h00, (b == 0) ? 8'hFF : 8'h00, rx);
            if (b == FB) chk("R12 zeros follow frame when off", rx, 8'h00);
        end
        cs_high();
    endtask

    task automatic t_reset_cmd();
        write_regs(5'h05, 1, 8'h55, 8'h00, 8'h00);
        write_regs(5'h01, 1, 8'h40, 8'h00, 8'h00);
        send_cmd(8'h06);
        chk("R4 reset pulse", n_reset, 1);
        chk("R4 reg 05h cleared", rg(5), 8'h00);
        chk("R4 reg 01h cleared", rg(1), 8'h00);
        chk("R1 sdo high-Z when deselected", {63'b0, sdo}, {63'b0, 1'bz});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset_state();
        t_strobes();
        t_write_read();
        t_fixed_and_id();
        t_abort();
        t_read_once();
        t_continuous();
        t_daisy();
        t_reset_cmd();
        finish_run();
    end
endmodule